// File: doc/BRIEF.md
# I2C Target Engine with Optional Clock Stretching

This block is the bus side of an I2C target (slave). It watches the SCL and SDA lines through a synchronizer, detects start and stop conditions, compares the first byte after a start with a 7-bit own address, and then receives or transmits bytes. The lines are never driven high. The engine only asserts a pull-low enable per line, so the wired-AND bus floats high whenever nobody pulls it down. Each direction has a one-byte data register in front of the shift register. A host writes that register for transmission or reads it after reception. The host uses single-cycle strobes and watches a set of status flags.

The stretch enable sets what happens at a byte boundary when the data register is not ready. This means a full receive register when a new byte completes, or an empty transmit register when the next byte must start. With stretching on, the engine holds SCL low until the host services the register. With stretching off, the bus keeps running and the engine raises an overrun or underrun flag instead. The engine starts in the target role after reset and has no controller role.

The state machine (`i2c_slv_pkg::slv_state_e`) has these states:

- S_IDLE: released.
- S_ADDR: shifting in the address byte.
- S_ADDR_ACK: driving the address ACK.
- S_RX_BITS: shifting in a data byte.
- S_RX_HOLD: SCL held, waiting for the receive register to be read.
- S_RX_ACK: driving the data ACK.
- S_TX_BITS: driving a data byte, MSB first.
- S_TX_HOLD: SCL held, waiting for a transmit byte.
- S_TX_MACK: sampling the controller's ACK bit.
- S_IGNORE: released until the next start or stop.

The transitions are:

- A stop goes from any state to S_IDLE.
- A start goes from any state to S_ADDR.
- From S_ADDR, the SCL fall after the eighth bit goes to S_ADDR_ACK on a match or to S_IGNORE on a mismatch.
- From S_ADDR_ACK, the closing SCL fall goes to S_RX_BITS for a write. For a read it goes to S_TX_BITS, or to S_TX_HOLD if the transmit register is empty and stretching is enabled.
- From S_RX_BITS, the fall after the eighth bit goes to S_RX_ACK, or to S_RX_HOLD if the receive register is full and stretching is enabled.
- S_RX_HOLD goes to S_RX_ACK once the receive register is empty, or once stretching is disabled.
- S_RX_ACK goes back to S_RX_BITS on the next SCL fall.
- From S_TX_BITS, the eighth fall goes to S_TX_MACK.
- From S_TX_MACK, the closing fall applies the same load decision as S_ADDR_ACK if the controller acknowledged, and goes to S_IGNORE if it did not.
- S_TX_HOLD goes to S_TX_BITS once a byte is written, or once stretching is disabled.

Top module: `i2c_slv_stretch`

## Requirements
- R1: After reset both pull-low enables are 0, flag_tx_empty=1, and flag_rx_full, flag_byte_done, flag_ovr, flag_udr, flag_addressed and flag_tx_mode are all 0.
- R2: A start is SDA falling while SCL is high, and it begins a new address phase from any state, including a repeated start. A stop is SDA rising while SCL is high. After a stop, the next cycle has both lines released and flag_addressed=0.
- R3: Bits 7..1 of the first byte after a start are compared with cfg_own_addr, with bits received MSB first. On a match the engine pulls SDA low during the ninth clock (ACK) and sets flag_addressed. Bit 0 then selects the direction, with 1 meaning the controller reads (flag_tx_mode=1) and 0 meaning the controller writes. On a mismatch SDA stays released (NACK) and flag_addressed stays 0.
- R4: In a write, each 8-bit byte (MSB first) is moved into the receive register if that register is empty. The move sets flag_rx_full and shows the byte on host_rd_data, and the engine then drives ACK.
- R5: In a read, the byte in the transmit register is loaded into the shift register and sent MSB first, which sets flag_tx_empty. A NACK from the controller ends the transfer, and SDA stays released until the next start or stop.
- R6: With cfg_stretch_en=1, a byte that completes while flag_rx_full=1 makes the engine hold SCL low. The hold lasts until a host_data_rd empties the register. The held byte is then delivered and acknowledged.
- R7: With cfg_stretch_en=1, the engine holds SCL low whenever a byte must be loaded for transmission while flag_tx_empty=1. The hold lasts until host_data_wr supplies a byte, and that byte is then sent.
- R8: With cfg_stretch_en=0, a byte that completes while flag_rx_full=1 sets flag_ovr. The new byte is discarded and host_rd_data keeps the unread byte.
- R9: With cfg_stretch_en=0, a byte needed while flag_tx_empty=1 sets flag_udr, and the byte sent previously is sent again. Before any byte has been sent, that previous byte is 0xFF.
- R10: flag_byte_done is set when an address match is acknowledged, when a received byte enters the register, and when a transmitted byte is acknowledged. It clears only after host_status_rd was seen while it was set, followed in a later cycle by host_data_rd or host_data_wr. A data access without that status read leaves it set.
- R11: host_clr_ovr clears flag_ovr and host_clr_udr clears flag_udr, each independently.
- R12: host_data_rd clears flag_rx_full. host_data_wr stores host_wr_data and clears flag_tx_empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_own_addr | input | 7 | Own 7-bit bus address |
| cfg_stretch_en | input | 1 | 1: hold SCL when the data register is not ready; 0: flag errors |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| host_status_rd | input | 1 | Strobe: host read the status flags |
| host_data_rd | input | 1 | Strobe: host read the receive register |
| host_data_wr | input | 1 | Strobe: host writes host_wr_data to the transmit register |
| host_wr_data | input | 8 | Byte to transmit |
| host_clr_ovr | input | 1 | Strobe: clear flag_ovr |
| host_clr_udr | input | 1 | Strobe: clear flag_udr |
| host_rd_data | output | 8 | Receive register contents |
| flag_rx_full | output | 1 | Receive register holds an unread byte |
| flag_tx_empty | output | 1 | Transmit register is empty |
| flag_byte_done | output | 1 | A byte has finished on the bus |
| flag_ovr | output | 1 | Sticky overrun error |
| flag_udr | output | 1 | Sticky underrun error |
| flag_addressed | output | 1 | Engine is selected in a transfer |
| flag_tx_mode | output | 1 | Selected transfer is a controller read |

## Verification
The bench builds the engine with SYNC_STAGES=2 and runs its bus model at 20 system clocks per SCL period. This leaves enough margin after each synchronized SCL fall for the engine to assert its hold before the controller model tries to release the clock. The held states are therefore reached on real bus timing. The controller model waits for the line to read high, so S_RX_HOLD and S_TX_HOLD can be observed while the host side is deliberately late. Directed cases cover overrun, underrun, the two-step byte-done clear and repeated start. A seeded random loop mixes directions, lengths, stretch settings and foreign addresses.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;

    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_RX_BITS,
        S_RX_HOLD,
        S_RX_ACK,
        S_TX_BITS,
        S_TX_HOLD,
        S_TX_MACK,
        S_IGNORE
    } slv_state_e;

endpackage

// File: rtl/i2c_slv_sync.sv
module i2c_slv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_p;
    logic              sda_p;

    // Synchronizer chain: one flop per stage, idle bus reads high.
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_q[g] <= 1'b1;
                    sda_q[g] <= 1'b1;
                end else begin
                    scl_q[g] <= scl_i;
                    sda_q[g] <= sda_i;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_q[g] <= 1'b1;
                    sda_q[g] <= 1'b1;
                end else begin
                    scl_q[g] <= scl_q[g-1];
                    sda_q[g] <= sda_q[g-1];
                end
            end
        end
    end

    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];

    // Previous synchronized sample of each line, used for edge detection.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_p;
    assign scl_fall = ~scl_s & scl_p;
    // Start/stop need SCL high in both samples.
    assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

    // At most one bus event per cycle.
    assert_edge_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_ev, stop_ev, scl_rise, scl_fall}));

endmodule

// File: rtl/i2c_slv_dreg.sv
module i2c_slv_dreg
    import i2c_slv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              status_rd,
    input  logic              data_rd,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              clr_ovr,
    input  logic              clr_udr,
    input  logic              rx_load,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              tx_take,
    input  logic              bf_set,
    input  logic              ovr_set,
    input  logic              udr_set,
    output logic [BYTE_W-1:0] rx_buf,
    output logic              rx_full,
    output logic [BYTE_W-1:0] tx_buf,
    output logic              tx_empty,
    output logic              bf,
    output logic              err_ovr,
    output logic              err_udr
);
    logic status_seen;
    logic bf_clear;

    assign bf_clear = bf & status_seen & (data_rd | data_wr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_buf      <= '0;
            rx_full     <= 1'b0;
            tx_buf      <= '0;
            tx_empty    <= 1'b1;
            bf          <= 1'b0;
            status_seen <= 1'b0;
            err_ovr     <= 1'b0;
            err_udr     <= 1'b0;
        end else begin
            if (rx_load) begin
                rx_buf  <= rx_byte;
                rx_full <= 1'b1;
            end else if (data_rd) begin
                rx_full <= 1'b0;
            end

            if (data_wr) begin
                tx_buf   <= wr_data;
                tx_empty <= 1'b0;
            end else if (tx_take) begin
                tx_empty <= 1'b1;
            end

            if (bf_set) begin
                bf <= 1'b1;
            end else if (bf_clear) begin
                bf <= 1'b0;
            end

            if (bf_set || bf_clear) begin
                status_seen <= 1'b0;
            end else if (status_rd && bf) begin
                status_seen <= 1'b1;
            end

            if (ovr_set) begin
                err_ovr <= 1'b1;
            end else if (clr_ovr) begin
                err_ovr <= 1'b0;
            end

            if (udr_set) begin
                err_udr <= 1'b1;
            end else if (clr_udr) begin
                err_udr <= 1'b0;
            end
        end
    end

    assert_bf_needs_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bf) |-> $past(status_seen));

    assert_ovr_keeps_rx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_set |=> $stable(rx_buf));

    assert_wr_fills_tx_R12: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> !tx_empty);

endmodule

// File: rtl/i2c_slv_stretch.sv
module i2c_slv_stretch
    import i2c_slv_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_own_addr,
    input  logic              cfg_stretch_en,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              host_status_rd,
    input  logic              host_data_rd,
    input  logic              host_data_wr,
    input  logic [BYTE_W-1:0] host_wr_data,
    input  logic              host_clr_ovr,
    input  logic              host_clr_udr,
    output logic [BYTE_W-1:0] host_rd_data,
    output logic              flag_rx_full,
    output logic              flag_tx_empty,
    output logic              flag_byte_done,
    output logic              flag_ovr,
    output logic              flag_udr,
    output logic              flag_addressed,
    output logic              flag_tx_mode
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

    slv_state_e        st, st_nx;
    logic [BYTE_W-1:0] sh, sh_nx;
    logic [BYTE_W-1:0] last_tx, last_nx;
    logic [CNT_W-1:0]  cnt, cnt_nx;
    logic              rw, rw_nx;
    logic              mack, mack_nx;
    logic              go_tx, go_rx;

    logic              rx_load, tx_take, bf_set, ovr_set, udr_set;
    logic [BYTE_W-1:0] tx_buf;

    i2c_slv_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    i2c_slv_dreg u_dreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .status_rd (host_status_rd),
        .data_rd   (host_data_rd),
        .data_wr   (host_data_wr),
        .wr_data   (host_wr_data),
        .clr_ovr   (host_clr_ovr),
        .clr_udr   (host_clr_udr),
        .rx_load   (rx_load),
        .rx_byte   (sh),
        .tx_take   (tx_take),
        .bf_set    (bf_set),
        .ovr_set   (ovr_set),
        .udr_set   (udr_set),
        .rx_buf    (host_rd_data),
        .rx_full   (flag_rx_full),
        .tx_buf    (tx_buf),
        .tx_empty  (flag_tx_empty),
        .bf        (flag_byte_done),
        .err_ovr   (flag_ovr),
        .err_udr   (flag_udr)
    );

    // Next-state and datapath decisions.
    always_comb begin
        st_nx   = st;
        sh_nx   = sh;
        cnt_nx  = cnt;
        rw_nx   = rw;
        mack_nx = mack;
        last_nx = last_tx;
        go_tx   = 1'b0;
        go_rx   = 1'b0;
        rx_load = 1'b0;
        tx_take = 1'b0;
        bf_set  = 1'b0;
        ovr_set = 1'b0;
        udr_set = 1'b0;

        if (stop_ev) begin
            st_nx = S_IDLE;
        end else if (start_ev) begin
            st_nx  = S_ADDR;
            cnt_nx = '0;
        end else begin
            unique case (st)
                S_IDLE, S_IGNORE: begin
                end
                S_ADDR: begin
                    if (scl_rise) begin
                        sh_nx  = {sh[BYTE_W-2:0], sda_s};
                        cnt_nx = cnt + 1'b1;
                    end else if (scl_fall && cnt == CNT_FULL) begin
                        if (sh[BYTE_W-1:1] == cfg_own_addr) begin
                            st_nx  = S_ADDR_ACK;
                            rw_nx  = sh[0];
                            bf_set = 1'b1;
                        end else begin
                            st_nx = S_IGNORE;
                        end
                    end
                end
                S_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (rw) begin
                            go_tx = 1'b1;
                        end else begin
                            st_nx  = S_RX_BITS;
                            cnt_nx = '0;
                        end
                    end
                end
                S_RX_BITS: begin
                    if (scl_rise) begin
                        sh_nx  = {sh[BYTE_W-2:0], sda_s};
                        cnt_nx = cnt + 1'b1;
                    end else if (scl_fall && cnt == CNT_FULL) begin
                        go_rx = 1'b1;
                    end
                end
                S_RX_HOLD: begin
                    go_rx = 1'b1;
                end
                S_RX_ACK: begin
                    if (scl_fall) begin
                        st_nx  = S_RX_BITS;
                        cnt_nx = '0;
                    end
                end
                S_TX_BITS: begin
                    if (scl_fall) begin
                        if (cnt == CNT_LAST) begin
                            st_nx = S_TX_MACK;
                        end else begin
                            sh_nx  = {sh[BYTE_W-2:0], 1'b0};
                            cnt_nx = cnt + 1'b1;
                        end
                    end
                end
                S_TX_HOLD: begin
                    go_tx = 1'b1;
                end
                S_TX_MACK: begin
                    if (scl_rise) begin
                        mack_nx = ~sda_s;
                    end else if (scl_fall) begin
                        if (mack) begin
                            bf_set = 1'b1;
                            go_tx  = 1'b1;
                        end else begin
                            st_nx = S_IGNORE;
                        end
                    end
                end
                default: st_nx = S_IDLE;
            endcase
        end

        // Receive byte boundary: deliver, hold SCL, or flag overrun.
        if (go_rx) begin
            if (!flag_rx_full) begin
                rx_load = 1'b1;
                bf_set  = 1'b1;
                st_nx   = S_RX_ACK;
            end else if (cfg_stretch_en) begin
                st_nx = S_RX_HOLD;
            end else begin
                ovr_set = 1'b1;
                st_nx   = S_RX_ACK;
            end
        end

        // Transmit byte boundary: load, hold SCL, or replay on underrun.
        if (go_tx) begin
            cnt_nx = '0;
            if (!flag_tx_empty) begin
                sh_nx   = tx_buf;
                last_nx = tx_buf;
                tx_take = 1'b1;
                st_nx   = S_TX_BITS;
            end else if (cfg_stretch_en) begin
                st_nx = S_TX_HOLD;
            end else begin
                sh_nx   = last_tx;
                udr_set = 1'b1;
                st_nx   = S_TX_BITS;
            end
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            sh      <= '0;
            last_tx <= '1;
            cnt     <= '0;
            rw      <= 1'b0;
            mack    <= 1'b0;
        end else begin
            st      <= st_nx;
            sh      <= sh_nx;
            last_tx <= last_nx;
            cnt     <= cnt_nx;
            rw      <= rw_nx;
            mack    <= mack_nx;
        end
    end

    // Outputs from state.
    always_comb begin
        scl_oe         = 1'b0;
        sda_oe         = 1'b0;
        flag_addressed = 1'b1;
        unique case (st)
            S_IDLE, S_ADDR, S_IGNORE: flag_addressed = 1'b0;
            S_ADDR_ACK, S_RX_ACK:     sda_oe = 1'b1;
            S_RX_HOLD, S_TX_HOLD:     scl_oe = 1'b1;
            S_TX_BITS:                sda_oe = ~sh[BYTE_W-1];
            S_RX_BITS, S_TX_MACK:     ;
            default:                  flag_addressed = 1'b0;
        endcase
        flag_tx_mode = flag_addressed & rw;
    end

    assert_hold_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> cfg_stretch_en);

    assert_stop_releases_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (!scl_oe && !sda_oe && !flag_addressed));

    assert_no_ack_on_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_ADDR && scl_fall && cnt == CNT_FULL && sh[BYTE_W-1:1] != cfg_own_addr && !start_ev && !stop_ev)
        |=> !sda_oe);

endmodule

// File: tb/i2c_slv_stretch_bench.sv
module i2c_slv_stretch_bench;
    localparam int CLK_P = 10;
    localparam int HALF  = 10;
    localparam int WD_CYCLES = 150000;
    localparam logic [6:0] OWN = 7'h5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    logic m_scl_low = 1'b0, m_sda_low = 1'b0;
    logic scl_oe, sda_oe, scl_line, sda_line;
    assign scl_line = ~(m_scl_low | scl_oe);
    assign sda_line = ~(m_sda_low | sda_oe);

    logic [6:0] own_addr = OWN;
    logic       st_en = 1'b0;
    logic       h_srd = 0, h_drd = 0, h_dwr = 0, h_cov = 0, h_cud = 0;
    logic [7:0] h_wdat = '0;
    logic [7:0] rd_data;
    logic       rx_full, tx_empty, bdone, ovr, udr, addressed, tx_mode;

    i2c_slv_stretch u_i2c_slv_stretch (
        .clk(clk), .rst_n(rst_n), .cfg_own_addr(own_addr), .cfg_stretch_en(st_en),
        .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .host_status_rd(h_srd), .host_data_rd(h_drd), .host_data_wr(h_dwr),
        .host_wr_data(h_wdat), .host_clr_ovr(h_cov), .host_clr_udr(h_cud),
        .host_rd_data(rd_data), .flag_rx_full(rx_full), .flag_tx_empty(tx_empty),
        .flag_byte_done(bdone), .flag_ovr(ovr), .flag_udr(udr),
        .flag_addressed(addressed), .flag_tx_mode(tx_mode)
    );

    int nchk = 0, nerr = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_ack(input logic [6:0] a, input logic [6:0] own);
        return a == own;
    endfunction

    function automatic logic [7:0] addr_byte(input logic [6:0] a, input bit rd);
        return {a, rd};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_up();
        m_scl_low = 1'b0;
        tick(1);
        while (!scl_line) tick(1);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0;
        tick(2);
        scl_up();
        tick(HALF/2);
        m_sda_low = 1'b1;
        tick(HALF/2);
        m_scl_low = 1'b1;
        tick(HALF);
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1;
        tick(2);
        scl_up();
        tick(HALF/2);
        m_sda_low = 1'b0;
        tick(HALF);
    endtask

    task automatic put_bit(input bit b);
        m_sda_low = ~b;
        tick(2);
        scl_up();
        tick(HALF);
        m_scl_low = 1'b1;
        tick(HALF-2);
    endtask

    task automatic get_bit(output bit b);
        m_sda_low = 1'b0;
        tick(2);
        scl_up();
        tick(HALF/2);
        b = sda_line;
        tick(HALF/2);
        m_scl_low = 1'b1;
        tick(HALF-2);
    endtask

    task automatic send_byte(input logic [7:0] v, output bit ack);
        bit x;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(x);
        ack = ~x;
    endtask

    task automatic recv_byte(output logic [7:0] v, input bit ack);
        bit x;
        for (int i = 7; i >= 0; i--) begin
            get_bit(x);
            v[i] = x;
        end
        put_bit(~ack);
    endtask

    task automatic do_srd(); h_srd = 1; tick(1); h_srd = 0; endtask
    task automatic do_drd(); h_drd = 1; tick(1); h_drd = 0; endtask
    task automatic do_cov(); h_cov = 1; tick(1); h_cov = 0; endtask
    task automatic do_cud(); h_cud = 1; tick(1); h_cud = 0; endtask
    task automatic do_dwr(input logic [7:0] v);
        h_wdat = v; h_dwr = 1; tick(1); h_dwr = 0;
    endtask

    // Host feeds the transmit register whenever it runs empty.
    task automatic host_feed(input logic [7:0] q [4], input int from, input int upto);
        for (int k = from; k < upto; k++) begin
            while (!tx_empty) tick(1);
            do_dwr(q[k]);
        end
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        bit ack, ack2, done;
        logic [7:0] b1, b2, r0, last_sent;
        logic [7:0] q [4];
        logic [7:0] got;
        logic [6:0] other;
        int n, k;

        void'($urandom(32'h00C0FFEE));
        tick(5);
        // R1 reset state
        chk(!scl_oe && !sda_oe, "R1 lines", {scl_oe, sda_oe}, 0);
        chk(tx_empty && !rx_full && !bdone, "R1 data flags", {tx_empty, rx_full, bdone}, 3'b100);
        chk(!ovr && !udr && !addressed && !tx_mode, "R1 status", {ovr, udr, addressed, tx_mode}, 0);
        rst_n = 1'b1;
        tick(5);

        // R3 mismatch
        other = OWN ^ 7'h11;
        bus_start();
        send_byte(addr_byte(other, 0), ack);
        chk(ack == exp_ack(other, own_addr), "R3 nack on miss", ack, 0);
        chk(!addressed, "R3 not addressed", addressed, 0);
        bus_stop();
        tick(3);
        chk(!scl_oe && !sda_oe, "R2 released after stop", {scl_oe, sda_oe}, 0);

        // Write, stretching off: R4, R8, R10, R11, R12
        st_en = 1'b0;
        bus_start();
        send_byte(addr_byte(OWN, 0), ack);
        chk(ack, "R3 ack on match", ack, 1);
        chk(addressed && !tx_mode, "R3 write selected", {addressed, tx_mode}, 2'b10);
        chk(bdone, "R10 set on address ack", bdone, 1);
        b1 = 8'($urandom);
        b2 = ~b1;
        send_byte(b1, ack);
        chk(ack && rx_full && rd_data == b1, "R4 byte received", rd_data, b1);
        send_byte(b2, ack);
        chk(ovr, "R8 overrun set", ovr, 1);
        chk(rd_data == b1, "R8 new byte dropped", rd_data, b1);
        do_cov();
        chk(!ovr, "R11 clear overrun", ovr, 0);
        do_drd();
        chk(!rx_full, "R12 read empties rx", rx_full, 0);
        chk(bdone, "R10 no clear without status read", bdone, 1);
        do_srd();
        do_drd();
        chk(!bdone, "R10 cleared after status then data", bdone, 0);
        bus_stop();
        tick(3);
        chk(!addressed, "R2 stop deselects", addressed, 0);

        // Write, stretching on: R6
        st_en = 1'b1;
        bus_start();
        send_byte(addr_byte(OWN, 0), ack);
        b1 = 8'($urandom);
        b2 = 8'($urandom);
        send_byte(b1, ack);
        done = 1'b0;
        fork
            begin
                send_byte(b2, ack2);
                done = 1'b1;
            end
            begin
                n = 0;
                while (!scl_oe && n < 1000) begin tick(1); n++; end
                tick(40);
                chk(scl_oe && !done, "R6 SCL held while rx full", {scl_oe, done}, 2'b10);
                chk(rd_data == b1, "R6 held data intact", rd_data, b1);
                do_srd();
                do_drd();
            end
        join
        chk(ack2 && rx_full && rd_data == b2, "R6 held byte delivered", rd_data, b2);
        chk(!ovr, "R6 no overrun when stretching", ovr, 0);
        do_srd();
        do_drd();
        bus_stop();

        // Read, stretching on: R7, R5, R12
        bus_start();
        send_byte(addr_byte(OWN, 1), ack);
        chk(ack && tx_mode, "R3 read selected", tx_mode, 1);
        r0 = 8'($urandom);
        fork
            recv_byte(got, 1'b1);
            begin
                tick(60);
                chk(scl_oe, "R7 SCL held while tx empty", scl_oe, 1);
                do_dwr(r0);
            end
        join
        chk(got == r0, "R7 written byte sent", got, r0);
        for (int i = 0; i < 4; i++) q[i] = 8'($urandom);
        fork
            host_feed(q, 0, 4);
            begin
                for (int i = 0; i < 4; i++) begin
                    recv_byte(got, i != 3);
                    chk(got == q[i], "R5 byte sent MSB first", got, q[i]);
                end
            end
        join
        last_sent = q[3];
        tick(4);
        chk(!sda_oe && tx_empty, "R5 released after nack", {sda_oe, tx_empty}, 2'b01);
        // repeated start into a write
        bus_start();
        send_byte(addr_byte(OWN, 0), ack);
        chk(ack && addressed && !tx_mode, "R2 repeated start", {ack, addressed, tx_mode}, 3'b110);
        bus_stop();

        // Underrun, stretching off: R9, R11
        st_en = 1'b0;
        bus_start();
        send_byte(addr_byte(OWN, 1), ack);
        recv_byte(got, 1'b0);
        chk(got == last_sent, "R9 previous byte replayed", got, last_sent);
        chk(udr, "R9 underrun set", udr, 1);
        do_cud();
        chk(!udr, "R11 clear underrun", udr, 0);
        bus_stop();
        do_srd();
        do_drd();

        // Seeded random transfers
        for (int it = 0; it < 12; it++) begin
            st_en = 1'($urandom);
            k = 1 + int'($urandom % 3);
            other = (($urandom % 4) == 0) ? (OWN ^ 7'($urandom | 1)) : OWN;
            for (int i = 0; i < 4; i++) q[i] = 8'($urandom);
            if (($urandom % 2) == 0) begin
                bus_start();
                send_byte(addr_byte(other, 0), ack);
                chk(ack == exp_ack(other, own_addr), "R3 random address", ack, exp_ack(other, own_addr));
                if (ack) begin
                    for (int i = 0; i < k; i++) begin
                        send_byte(q[i], ack2);
                        chk(ack2 && rd_data == q[i], "R4 random write", rd_data, q[i]);
                        do_srd();
                        do_drd();
                    end
                end
                bus_stop();
            end else begin
                do_dwr(q[0]);
                bus_start();
                send_byte(addr_byte(other, 1), ack);
                chk(ack == exp_ack(other, own_addr), "R3 random address", ack, exp_ack(other, own_addr));
                if (ack) begin
                    fork
                        host_feed(q, 1, k);
                        begin
                            for (int i = 0; i < k; i++) begin
                                recv_byte(got, i != k - 1);
                                chk(got == q[i], "R5 random read", got, q[i]);
                            end
                        end
                    join
                end else begin
                    chk(!tx_empty, "R5 untouched on miss", tx_empty, 0);
                    // drain the preloaded byte through a real read
                    bus_stop();
                    bus_start();
                    send_byte(addr_byte(OWN, 1), ack);
                    recv_byte(got, 1'b0);
                    chk(got == q[0], "R5 preloaded byte", got, q[0]);
                end
                bus_stop();
            end
            tick(3);
            chk(!scl_oe && !sda_oe && !addressed, "R2 idle between transfers", {scl_oe, sda_oe, addressed}, 0);
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule